// File: doc/BRIEF.md
# Fixed-Point MAC Tile Array

This block is the arithmetic core of a convolution engine that has lowered convolution to matrix multiplication. A grid of ROWS×COLS multiply-accumulate cells computes one output tile. On each accepted step the caller presents one vector of ROWS weights, one weight for each output channel. It also presents one vector of COLS feature pixels, one pixel for each output column. Cell (i,j) adds the product of weight lane i and pixel lane j to its own accumulator. A tile takes as many steps as the reduction length, for example c·k·k for a k×k kernel over c input channels.

The caller marks the opening step of a tile with a first flag and its closing step with a last flag. On the closing step the block captures the finished sums, truncated to pixel precision, into a shadow store. It then emits the tile one row per cycle for ROWS cycles. The accumulators are free again at once, so the next tile can accumulate while the previous one drains. When every tile is at least ROWS steps long, the array never stalls.

Top module: `mac_tile_array`

## Requirements
- R1: After reset, out_valid is low and stays low until a step carrying the last flag is accepted.
- R2: Weight lane i sits at wgt_vec[8i+7:8i] and pixel lane j at pix_vec[16j+15:16j]. Cell (i,j) accumulates the signed product of these two lanes on every step with in_valid high.
- R3: Weights are signed with 7 fraction bits and pixels are signed with 8 fraction bits. Each product is sign-extended into a 32-bit signed accumulator that holds 15 fraction bits, with no shift.
- R4: Each output element is accumulator bits [22:7]. The 7 lowest fraction bits are dropped and the upper bits are discarded, so an out-of-range value wraps. For example, (-1.0)×(-128.0) gives 16'h8000.
- R5: In the cycle after a step with the last flag is accepted, out_valid rises with out_row_idx 0. It stays high for ROWS consecutive cycles while out_row_idx counts 0 to ROWS-1. Element j of row r is at out_row[16j+15:16j].
- R6: A step with in_first high loads each accumulator with its product and discards any earlier partial sum.
- R7: While in_valid is low, in_first, in_last and both data vectors have no effect on the accumulators or on the drain.
- R8: Steps of a new tile can be accepted while a previous tile drains, and they do not disturb the rows being emitted.
- R9: A last step may be accepted in the cycle that shows row ROWS-1. The next drain then starts in the following cycle, with no gap. A last step is never accepted while an earlier row is still showing.
- R10: A step with both in_first and in_last high forms a complete one-step tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Step accepted on this edge |
| in_first | input | 1 | Opening step of a tile |
| in_last | input | 1 | Closing step of a tile |
| wgt_vec | input | ROWS*8 | Packed weight lanes |
| pix_vec | input | COLS*16 | Packed pixel lanes |
| out_valid | output | 1 | A result row is presented |
| out_row_idx | output | clog2(ROWS) | Index of the presented row |
| out_row | output | COLS*16 | Packed truncated results of the row |

## Verification
Two functions of the block can fall in the same cycle: the final row of one tile's drain and the acceptance of the next tile's closing step. The bench provokes this by driving tiles of exactly ROWS steps back to back, so each closing step lands on the row ROWS-1 cycle. The scoreboard then requires that the new tile's row 0 follows in the very next cycle. It also requires that every row of both tiles matches the bench's model. Stalls and garbage data on idle cycles are mixed into neighbouring tiles, so a leak between the capture, drain and accumulate paths appears as a miscompare.

// File: rtl/mac_tile_array.sv
module mac_tile_array #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WGT_W = 8,
  parameter int PIX_W = 16,
  parameter int ACC_W = 32,
  parameter int DROP  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_first,
  input  logic                      in_last,
  input  logic [ROWS*WGT_W-1:0]     wgt_vec,
  input  logic [COLS*PIX_W-1:0]     pix_vec,
  output logic                      out_valid,
  output logic [(ROWS>1 ? $clog2(ROWS) : 1)-1:0] out_row_idx,
  output logic [COLS*PIX_W-1:0]     out_row
);
  localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int MSB    = DROP + PIX_W - 1;
  localparam logic [RIDX_W-1:0] LAST_ROW = RIDX_W'(ROWS - 1);

  logic [PIX_W-1:0] shadow [ROWS][COLS];
  logic             drain;
  logic [RIDX_W-1:0] row;

  wire take      = in_valid;
  wire take_last = in_valid && in_last;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_col
      logic signed [ACC_W-1:0] acc, prod, nxt;
      assign prod = ACC_W'($signed(wgt_vec[i*WGT_W +: WGT_W])) *
                    ACC_W'($signed(pix_vec[j*PIX_W +: PIX_W]));
      assign nxt  = (in_first ? '0 : acc) + prod;
      always_ff @(posedge clk) begin
        if (!rst_n)         acc <= '0;
        else if (take)      acc <= nxt;
      end
      always_ff @(posedge clk) begin
        if (take_last) shadow[i][j] <= nxt[MSB:DROP];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain <= 1'b0;
      row   <= '0;
    end else if (take_last) begin
      drain <= 1'b1;
      row   <= '0;
    end else if (drain) begin
      if (row == LAST_ROW) drain <= 1'b0;
      else                 row   <= row + RIDX_W'(1);
    end
  end

  assign out_valid   = drain;
  assign out_row_idx = row;
  for (genvar j = 0; j < COLS; j++) begin : g_out
    assign out_row[j*PIX_W +: PIX_W] = shadow[row][j];
  end
endmodule

module mac_tile_array_chk #(
  parameter int ROWS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_last,
  input logic out_valid,
  input logic [(ROWS>1 ? $clog2(ROWS) : 1)-1:0] out_row_idx
);
  localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [RIDX_W-1:0] LAST_ROW = RIDX_W'(ROWS - 1);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !(in_valid && in_last)) |=> !out_valid);

  assert_drain_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (out_valid && out_row_idx == '0));

  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row_idx != LAST_ROW && !(in_valid && in_last)) |=>
    (out_valid && out_row_idx == RIDX_W'($past(out_row_idx) + RIDX_W'(1))));

  assert_drain_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row_idx == LAST_ROW && !(in_valid && in_last)) |=> !out_valid);

  assert_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && out_valid) |-> out_row_idx == LAST_ROW);
endmodule

bind mac_tile_array mac_tile_array_chk #(.ROWS(ROWS)) u_chk (.*);

// File: tb/sim_mac_tile_array.sv
module sim_mac_tile_array;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [ROWS*8-1:0]  wgt_vec = '0;
  logic [COLS*16-1:0] pix_vec = '0;
  logic out_valid;
  logic [RW-1:0] out_row_idx;
  logic [COLS*16-1:0] out_row;

  always #2.5 clk = ~clk;

  mac_tile_array u0 (.*);

  typedef struct {
    int idx;
    logic [COLS*16-1:0] row;
    string req;
  } exp_t;
  exp_t q[$];

  int nchk = 0, nfail = 0;
  longint msum [ROWS][COLS];

  task automatic drive(input logic v, input logic f, input logic l,
                       input logic [ROWS*8-1:0] w, input logic [COLS*16-1:0] p);
    in_valid = v; in_first = f; in_last = l; wgt_vec = w; pix_vec = p;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++)
      drive(1'b0, 1'($urandom), 1'($urandom), ROWS*8'($urandom), {$urandom, $urandom});
  endtask

  // mode 0: random lanes, mode 1: most negative weight and pixel
  task automatic send_tile(input int n, input int gap, input int mode,
                           input bit has_last, input string req);
    for (int s = 0; s < n; s++) begin
      logic [ROWS*8-1:0]  w;
      logic [COLS*16-1:0] p;
      w = (mode == 1) ? {ROWS{8'h80}} : ROWS*8'({$urandom, $urandom});
      p = (mode == 1) ? {COLS{16'h8000}} : {$urandom, $urandom};
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          longint pr;
          pr = longint'($signed(w[r*8 +: 8])) * longint'($signed(p[c*16 +: 16]));
          msum[r][c] = (s == 0) ? pr : msum[r][c] + pr;
        end
      if (has_last && s == n - 1) begin
        for (int r = 0; r < ROWS; r++) begin
          exp_t e;
          e.idx = r; e.req = req;
          for (int c = 0; c < COLS; c++) e.row[c*16 +: 16] = 16'(msum[r][c] >>> 7);
          q.push_back(e);
        end
      end
      drive(1'b1, s == 0, has_last && s == n - 1, w, p);
      if (s != n - 1 && gap > 0) idle(gap);
    end
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      nchk++;
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL R5: unexpected row idx=%0d data=%h, expected no output", out_row_idx, out_row);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (int'(out_row_idx) != e.idx || out_row !== e.row) begin
          nfail++;
          $display("FAIL %s: row idx=%0d data=%h, expected idx=%0d data=%h",
                   e.req, out_row_idx, out_row, e.idx, e.row);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0) begin
      nfail++;
      $display("FAIL R1: out_valid=%b after reset, expected 0", out_valid);
    end
    @(posedge clk); #1;
    idle(3);

    send_tile(9, 0, 0, 1, "R2 R3 R5");
    idle(ROWS + 1);
    send_tile(5, 2, 0, 1, "R7");
    idle(ROWS + 1);
    send_tile(3, 0, 0, 0, "R6");
    send_tile(4, 0, 0, 1, "R6");
    idle(ROWS + 1);
    send_tile(1, 0, 1, 1, "R4 R10");
    idle(ROWS + 1);
    send_tile(3, 0, 1, 1, "R4");
    idle(ROWS + 1);
    send_tile(4, 0, 0, 1, "R8");
    send_tile(4, 0, 0, 1, "R9");
    send_tile(6, 0, 0, 1, "R8 R9");
    send_tile(ROWS, 1, 0, 1, "R8");
    idle(ROWS + 1);
    send_tile(27, 0, 0, 1, "R2");
    idle(ROWS + 4);

    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R5: %0d rows never drained, expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule